// File: doc/BRIEF.md
# 32-bit Data-Processing Execute Unit

This block is the arithmetic and logic stage of a 32-bit processor's data-processing path. It is purely combinational. It receives four things: the instruction word, the first operand already read from the register file, the second operand already formed by an external shifter, and that shifter's carry-out. It also receives the current condition flags. From these it forms the 32-bit result, the destination register index and a write enable. It also forms the next flag values, a flag-update enable, and a request to restore the processor mode.

Sixteen operations are decoded from a 4-bit field. They cover logical operations, add and subtract, reverse subtract, the carry-chained forms, and four test/compare forms that only set flags. A single shared adder serves every arithmetic operation; the operand order, inversion and carry-in are selected per operation. When the flag-setting bit is set and a writing operation targets register 15, the unit asks for a mode restore instead of updating the flags.

Top module: `dp_exec_unit`

## Requirements
- R1: The operation code is instruction bits 24:21 and the flag-setting bit S is bit 20. `rd_idx` always equals instruction bits 15:12. The operation codes 0..15 are AND, EOR, SUB, RSB, ADD, ADC, SBC, RSC, TST, TEQ, CMP, CMN, ORR, MOV, BIC, MVN.
- R2: The arithmetic results, computed modulo 2^32, are:
  - SUB and CMP: a-b
  - RSB: b-a
  - ADD and CMN: a+b
  - ADC: a+b+C
  - SBC: a-b-1+C
  - RSC: b-a-1+C

  Here a is `op_a`, b is `op_b` and C is `flags_in[1]`.
- R3: The logical results are:
  - AND and TST: a&b
  - EOR and TEQ: a^b
  - ORR: a|b
  - MOV: b
  - BIC: a&~b
  - MVN: ~b
- R4: Codes 8..11 (code bits 3:2 = 2'b10) never assert `rd_we`. All other codes always assert it.
- R5: When S is clear, `flags_we` is low and `flags_out` equals `flags_in`. Flags are packed as [3]=N, [2]=Z, [1]=C, [0]=V.
- R6: For a logical code with `flags_we` high, the flags are set as follows:
  - N is result bit 31.
  - Z is set when the result is zero.
  - C equals `shift_c`.
  - V keeps the value of `flags_in[0]`.
- R7: For an arithmetic code with `flags_we` high, N and Z come from the result. C is the carry out of the addition, which means "no borrow" for the subtract forms. V is set when the exact signed result does not fit in 32 bits. RSB and RSC take their flags from b minus a.
- R8: When S is set, `rd_we` is high and `rd_idx` is 15, `mode_restore` is high, `flags_we` is low and `flags_out` equals `flags_in`. `mode_restore` is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word (code 24:21, S 20, Rd 15:12) |
| op_a | input | 32 | First operand, from the register named by bits 19:16 |
| op_b | input | 32 | Second operand from the external shifter |
| shift_c | input | 1 | Carry-out of the external shifter |
| flags_in | input | 4 | Current N, Z, C, V |
| result | output | 32 | Computed value, also driven for the compare codes |
| rd_idx | output | 4 | Destination register index |
| rd_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next N, Z, C, V |
| flags_we | output | 1 | Flag-update enable |
| mode_restore | output | 1 | Mode-restore request for an S-bit write to register 15 |

## Verification
Two functions can fall in the same evaluation: the flag update and the mode restore. Both are keyed on the S bit, and the restore must win. The sweep provokes this by setting S with every writing code while the destination is register 15, and also with the compare codes aimed at register 15. In these cases the bench checks three things: that the request appears only for writing codes, that `flags_we` drops, and that `flags_out` returns `flags_in` unchanged even when the arithmetic would have moved the carry or overflow flag.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    function automatic logic op_is_logical(dp_op_e op);
        unique case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dp_exec_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 4,
    parameter int OP_LSB  = 21,
    parameter int S_POS   = 20,
    parameter int RD_LSB  = 12
) (
    input  logic [INSTR_W-1:0] instr,
    output dp_op_e             op,
    output logic               s_bit,
    output logic [IDX_W-1:0]   rd,
    output logic               writes_rd,
    output logic               is_logic
);
    localparam int OP_W = 4;

    always_comb begin
        op        = dp_op_e'(instr[OP_LSB +: OP_W]);
        s_bit     = instr[S_POS];
        rd        = instr[RD_LSB +: IDX_W];
        writes_rd = (instr[OP_LSB+2 +: 2] != 2'b10);
        is_logic  = op_is_logical(op);
    end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub
    import dp_exec_pkg::*;
#(
    parameter int W = 32
) (
    input  dp_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         ovf
);
    logic [W-1:0] x, y;
    logic         ci;
    logic [W:0]   wide;

    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1; end
            OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
            OP_ADD, OP_CMN: begin x = a; y = b;  ci = 1'b0; end
            OP_ADC:         begin x = a; y = b;  ci = c_in; end
            OP_SBC:         begin x = a; y = ~b; ci = c_in; end
            OP_RSC:         begin x = b; y = ~a; ci = c_in; end
            default:        begin x = a; y = b;  ci = 1'b0; end
        endcase
        wide  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        sum   = wide[W-1:0];
        c_out = wide[W];
        ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end

endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dp_exec_pkg::*;
#(
    parameter int W = 32
) (
    input  dp_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
    import dp_exec_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 4,
    parameter int PC_IDX  = 15
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic               shift_c,
    input  logic [3:0]         flags_in,
    output logic [DATA_W-1:0]  result,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               rd_we,
    output logic [3:0]         flags_out,
    output logic               flags_we,
    output logic               mode_restore
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    dp_op_e             op;
    logic               s_bit, writes_rd, is_logic;
    logic [IDX_W-1:0]   rd;
    logic [DATA_W-1:0]  arith_res, logic_res;
    logic               arith_c, arith_v;
    dp_flags_t          cur, nxt;

    assign cur = dp_flags_t'(flags_in);

    dp_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_dec (
        .instr(instr), .op(op), .s_bit(s_bit), .rd(rd),
        .writes_rd(writes_rd), .is_logic(is_logic)
    );

    dp_addsub #(.W(DATA_W)) u_add (
        .op(op), .a(op_a), .b(op_b), .c_in(cur.c),
        .sum(arith_res), .c_out(arith_c), .ovf(arith_v)
    );

    dp_logic #(.W(DATA_W)) u_log (
        .op(op), .a(op_a), .b(op_b), .res(logic_res)
    );

    always_comb begin
        result       = is_logic ? logic_res : arith_res;
        rd_idx       = rd;
        rd_we        = writes_rd;
        mode_restore = s_bit && writes_rd && (rd == PC_SEL);
        flags_we     = s_bit && !mode_restore;
        nxt          = cur;
        if (flags_we) begin
            nxt.n = result[DATA_W-1];
            nxt.z = (result == '0);
            nxt.c = is_logic ? shift_c : arith_c;
            nxt.v = is_logic ? cur.v   : arith_v;
        end
        flags_out = nxt;
    end

endmodule

// File: rtl/dp_exec_chk.sv
module dp_exec_chk #(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 4
) (
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  op_a,
    input logic [DATA_W-1:0]  op_b,
    input logic               shift_c,
    input logic [3:0]         flags_in,
    input logic [DATA_W-1:0]  result,
    input logic [IDX_W-1:0]   rd_idx,
    input logic               rd_we,
    input logic [3:0]         flags_out,
    input logic               flags_we,
    input logic               mode_restore
);
    logic [3:0] code;
    logic       sbit, logical;
    assign code    = instr[24:21];
    assign sbit    = instr[20];
    assign logical = (code inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});

    always_comb begin
        // R4
        no_wb_chk: assert (!(code[3:2] == 2'b10 && rd_we));
        // R5
        s_clear_chk: assert (sbit || (!flags_we && flags_out == flags_in));
        // R8
        restore_chk: assert (!mode_restore || (rd_we && rd_idx == 4'd15 && !flags_we && flags_out == flags_in));
        // R6
        logic_v_chk: assert (!(flags_we && logical) || (flags_out[0] == flags_in[0] && flags_out[1] == shift_c));
        // R7
        zero_flag_chk: assert (!flags_we || (flags_out[2] == (result == '0)));
        // R1
        rd_field_chk: assert (rd_idx == instr[15:12]);
    end

endmodule

bind dp_exec_unit dp_exec_chk u_chk (.*);

// File: tb/sim_dp_exec_unit.sv
module sim_dp_exec_unit;
    logic        clk = 1'b0;
    logic [31:0] instr, op_a, op_b, result;
    logic        shift_c, rd_we, flags_we, mode_restore;
    logic [3:0]  flags_in, flags_out, rd_idx;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dp_exec_unit u0 (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [31:0] pats [6] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h1234_5678};

    initial begin
        @(negedge clk);
        instr = '0; op_a = '0; op_b = '0; shift_c = 1'b0; flags_in = 4'h0;
        #1;
        chk("R1", "idle rd_idx", {28'h0, rd_idx}, 32'h0);
        chk("R4", "idle rd_we", {31'h0, rd_we}, 32'h1);
        chk("R5", "idle flags_we", {31'h0, flags_we}, 32'h0);
        chk("R8", "idle restore", {31'h0, mode_restore}, 32'h0);

        for (int op = 0; op < 16; op++)
        for (int s = 0; s < 2; s++)
        for (int rdsel = 0; rdsel < 2; rdsel++)
        for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
        for (int cf = 0; cf < 2; cf++) begin
            logic [31:0] a, b, p, q, exp_r;
            logic [3:0]  rdv, exp_f;
            logic        logical, writes, restore, fwe, ec, ev;
            longint      sd;
            longint unsigned ud;
            a = pats[ia]; b = pats[ib];
            rdv = rdsel ? 4'd15 : 4'(op ^ ia);
            logical = (op inside {0, 1, 8, 9, 12, 13, 14, 15});
            writes  = !(op >= 8 && op <= 11);
            p = (op == 3 || op == 7) ? b : a;
            q = (op == 3 || op == 7) ? a : b;
            ec = 1'b0; ev = 1'b0; exp_r = '0;
            case (op)
                0, 8:  exp_r = a & b;
                1, 9:  exp_r = a ^ b;
                12:    exp_r = a | b;
                13:    exp_r = b;
                14:    exp_r = a & ~b;
                15:    exp_r = ~b;
                4, 5, 11: begin
                    ud = longint'(p) + longint'(q) + ((op == 5) ? longint'(cf) : 0);
                    exp_r = ud[31:0]; ec = ud[32];
                    sd = longint'($signed(p)) + longint'($signed(q)) + ((op == 5) ? longint'(cf) : 0);
                    ev = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
                end
                default: begin
                    longint unsigned br;
                    br = (op == 6 || op == 7) ? longint'(1 - cf) : 0;
                    exp_r = p - q - br[31:0];
                    ec = (longint'(p) >= longint'(q) + br);
                    sd = longint'($signed(p)) - longint'($signed(q)) - longint'(br);
                    ev = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
                end
            endcase
            restore = s[0] && writes && rdv == 4'd15;
            fwe = s[0] && !restore;
            exp_f = {1'b1, 1'b0, cf[0], ~cf[0]};
            if (fwe)
                exp_f = {exp_r[31], exp_r == 0, logical ? ~cf[0] : ec, logical ? ~cf[0] : ev};
            @(negedge clk);
            instr = {7'b1110000, op[3:0], s[0], 4'(ia), rdv, 12'h0};
            op_a = a; op_b = b; shift_c = ~cf[0];
            flags_in = {1'b1, 1'b0, cf[0], ~cf[0]};
            #1;
            chk(logical ? "R3" : "R2", "result", result, exp_r);
            chk("R1", "rd_idx", {28'h0, rd_idx}, {28'h0, rdv});
            chk("R4", "rd_we", {31'h0, rd_we}, {31'h0, writes});
            chk("R8", "mode_restore", {31'h0, mode_restore}, {31'h0, restore});
            if (!s[0]) chk("R5", "flags_we S clear", {31'h0, flags_we}, 32'h0);
            else       chk("R8", "flags_we S set", {31'h0, flags_we}, {31'h0, fwe});
            chk(!fwe ? (s[0] ? "R8" : "R5") : (logical ? "R6" : "R7"), "flags_out",
                {28'h0, flags_out}, {28'h0, exp_f});
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule